// File: doc/BRIEF.md
# Bus Test Port with Interrupt Vector

This block is a small peripheral that sits on an 8-bit external I/O bus. It has one I/O address. A write cycle to that address stores a byte that drives a row of LEDs. A read cycle from that address returns the setting of a bank of switches. During an interrupt-acknowledge cycle, the same read path puts a fixed vector byte on the bus instead of the switches. The processor uses that byte as the low half of a pointer into its vector table.

A peripheral raises a request on `req_in`. A rising edge on this input sets a pending flag. The pending flag drives a front-panel lamp directly. The same flag, gated by an enable switch, drives the active-low interrupt line. The pending flag clears when the acknowledge cycle ends. The block drives the data bus only while a read to its address or an acknowledge is in progress. At all other times the data bus is left free for other devices.

All bus strobes are active low and are sampled on the rising edge of `clk`. The read path is combinational: it answers in the same cycle as the strobes. Every pin is a plain control or data pin. There is no valid/ready handshake, because the bus strobes alone mark when data is transferred. A write is accepted at once and cannot be stalled. A read cannot be held off by back-pressure.

Top module: `bus_test_port`

## Requirements
- R1: On the first rising clock edge at which `io_cyc_n`=0, `wr_n`=0, `iack_n`=1 and `addr`=PORT_ADDR (FFH by default), `leds` takes `data_in`. If the strobe is held low on later edges, `leds` does not change again, even if `data_in` changes.
- R2: A write to any other address, or a write with `io_cyc_n`=1, leaves `leds` unchanged.
- R3: While reset is held, and after it is released, `leds` is 00H, `lamp` is 0, `irq_n` is 1 and `data_oe` is 0.
- R4: While `io_cyc_n`=0, `rd_n`=0, `iack_n`=1 and `addr`=PORT_ADDR, `data_oe` is 1 and `data_out` equals `switches`, in the same cycle.
- R5: While `io_cyc_n`=0 and `iack_n`=0, `data_oe` is 1 and `data_out` is the VECTOR parameter with bit 0 forced to 0. With the defaults this value is 02H. An acknowledge wins over a port read that happens at the same time.
- R6: In any cycle with no decoded read and no acknowledge, `data_oe` is 0. This includes a read from another address and a read with `io_cyc_n`=1.
- R7: A rising edge on `req_in` sets the pending flag on that clock edge. A level on `req_in` that stays high does not set the flag again. `lamp` shows the pending flag whatever the value of `int_en`.
- R8: `irq_n` is 0 exactly when the pending flag is set and `int_en` is 1.
- R9: The pending flag clears on the first clock edge after the acknowledge ends. If a new rising edge of `req_in` arrives on that same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | I/O address |
| data_in | input | DATA_W | Write data from the bus |
| data_out | output | DATA_W | Read data or vector byte |
| data_oe | output | 1 | Enable for the data bus driver; 0 means the bus is released (high impedance) |
| io_cyc_n | input | 1 | I/O cycle strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| iack_n | input | 1 | Interrupt acknowledge strobe, active low |
| switches | input | DATA_W | Switch bank value |
| leds | output | DATA_W | Value held in the LED latch |
| req_in | input | 1 | Interrupt request from a peripheral (rising edge sets the pending flag) |
| int_en | input | 1 | Interrupt enable switch |
| irq_n | output | 1 | Interrupt request to the processor, active low |
| lamp | output | 1 | Front-panel indicator for a pending request |

## Verification
Two kinds of event can fall in the same cycle, and the bench forces both.

First, a port read and an acknowledge can both be active. The bench holds `rd_n` low at the port address while it pulls `iack_n` low. The check passes only if the bus carries the vector byte and not the switch value.

Second, the end of an acknowledge can coincide with a new request. The bench raises `req_in` on the same clock edge at which the acknowledge ends. The check passes only if `lamp` stays lit afterwards, where a plain acknowledge would have cleared it.

// File: rtl/btp_pkg.sv
package btp_pkg;

  // Decoded bus activity for one cycle
  typedef struct packed {
    logic wr;
    logic rd;
    logic ack;
  } bus_act_t;

  // The vector byte must point at a word-aligned table slot
  function automatic logic [7:0] align_vector(input logic [7:0] v);
    return {v[7:1], 1'b0};
  endfunction

endpackage

// File: rtl/btp_decode.sv
module btp_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_cyc_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iack_n,
  output btp_pkg::bus_act_t act
);
  logic hit;
  logic io;

  always_comb begin
    hit     = (addr == PORT_ADDR);
    io      = ~io_cyc_n;
    act.ack = io & ~iack_n;
    act.rd  = io & ~rd_n & hit & iack_n;
    act.wr  = io & ~wr_n & hit & iack_n;
  end
endmodule

// File: rtl/btp_led_latch.sv
module btp_led_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] led
);
  logic wr_q;
  logic cap;

  assign cap = wr_act & ~wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      led  <= '0;
    end else begin
      wr_q <= wr_act;
      if (cap) led <= din;
    end
  end

  // R1: a new write loads the input byte
  p_led_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && !wr_q) |=> (led == $past(din)));

  // R2: no write edge means the latch keeps its value
  p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |=> $stable(led));
endmodule

// File: rtl/btp_irq_ctrl.sv
module btp_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic ack_act,
  input  logic int_en,
  output logic pending,
  output logic irq_n
);
  logic req_q;
  logic ack_q;
  logic set_ev;
  logic ack_done;

  assign set_ev   = req_in & ~req_q;
  assign ack_done = ack_q & ~ack_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_q <= req_in;
      ack_q <= ack_act;
      if (set_ev)        pending <= 1'b1;
      else if (ack_done) pending <= 1'b0;
    end
  end

  assign irq_n = ~(pending & int_en);

  // R7: a fresh request edge always leaves the flag set
  p_req_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in && !req_q) |=> pending);

  // R9: end of acknowledge without a new edge clears the flag
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_act && ack_q && !(req_in && !req_q)) |=> !pending);
endmodule

// File: rtl/bus_test_port.sv
module bus_test_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '1,
  parameter logic [7:0] VECTOR = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              io_cyc_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iack_n,
  input  logic [DATA_W-1:0] switches,
  output logic [DATA_W-1:0] leds,
  input  logic              req_in,
  input  logic              int_en,
  output logic              irq_n,
  output logic              lamp
);
  localparam logic [7:0] VEC_AL = btp_pkg::align_vector(VECTOR);
  localparam logic [DATA_W-1:0] VEC_BUS = DATA_W'(VEC_AL);

  btp_pkg::bus_act_t act;
  logic pending;

  btp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(addr), .io_cyc_n(io_cyc_n), .rd_n(rd_n), .wr_n(wr_n),
    .iack_n(iack_n), .act(act)
  );

  btp_led_latch #(.DATA_W(DATA_W)) u_led (
    .clk(clk), .rst_n(rst_n), .wr_act(act.wr), .din(data_in), .led(leds)
  );

  btp_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_act(act.ack),
    .int_en(int_en), .pending(pending), .irq_n(irq_n)
  );

  assign lamp = pending;

  always_comb begin
    data_oe  = act.rd | act.ack;
    data_out = '0;
    if (act.ack)     data_out = VEC_BUS;
    else if (act.rd) data_out = switches;
  end

  // R6: the bus is released outside an I/O cycle
  p_bus_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_cyc_n |-> !data_oe);

  // R5: the vector byte on the bus is word aligned
  p_vector_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_cyc_n && !iack_n) |-> (data_oe && !data_out[0]));

  // R8: request line never asserted while the enable switch is off
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> irq_n);
endmodule

// File: tb/bus_test_port_test.sv
module bus_test_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_oe;
  logic       io_cyc_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, iack_n = 1'b1;
  logic [7:0] switches = 8'h00;
  logic [7:0] leds;
  logic       req_in = 1'b0, int_en = 1'b0;
  logic       irq_n, lamp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] last_led = 8'h00;

  always #5 clk = ~clk;

  bus_test_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .io_cyc_n(io_cyc_n),
    .rd_n(rd_n), .wr_n(wr_n), .iack_n(iack_n), .switches(switches),
    .leds(leds), .req_in(req_in), .int_en(int_en), .irq_n(irq_n),
    .lamp(lamp)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every LED change must match the next queued value
  always @(negedge clk) begin
    if (rst_n && leds !== last_led) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1/R2 unexpected led change actual=%h expected=%h", leds, last_led);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (leds !== e) begin
          fails++;
          $display("FAIL R1 led actual=%h expected=%h", leds, e);
        end
      end
      last_led = leds;
    end
  end

  // Driver: one write cycle; push expectation when it should land
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                           input logic io, input bit expect_hit);
    @(negedge clk);
    addr = a; data_in = d; io_cyc_n = ~io; wr_n = 1'b0;
    if (expect_hit) exp_q.push_back(d);
    @(negedge clk);
    io_cyc_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #1;
    // R3: reset state
    chk("R3 leds", leds, 8'h00);
    chk("R3 oe", {7'b0, data_oe}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 lamp", {7'b0, lamp}, 8'h00);
    chk("R3 irq_n", {7'b0, irq_n}, 8'h01);

    // R1: plain writes
    bus_write(8'hFF, 8'h55, 1'b1, 1'b1);
    bus_write(8'hFF, 8'hAA, 1'b1, 1'b1);
    // R2: ignored writes
    bus_write(8'hFE, 8'h33, 1'b1, 1'b0);
    bus_write(8'hFF, 8'h44, 1'b0, 1'b0);
    chk("R2 leds kept", leds, 8'hAA);

    // R1: held strobe, data changes: only the first byte lands
    @(negedge clk);
    addr = 8'hFF; data_in = 8'h3C; io_cyc_n = 1'b0; wr_n = 1'b0;
    exp_q.push_back(8'h3C);
    @(negedge clk); data_in = 8'hC3;
    @(negedge clk); data_in = 8'h99;
    @(negedge clk); io_cyc_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk("R1 held strobe", leds, 8'h3C);

    // R4: port read
    switches = 8'hA5; addr = 8'hFF; io_cyc_n = 1'b0; rd_n = 1'b0; #1;
    chk("R4 oe", {7'b0, data_oe}, 8'h01);
    chk("R4 data", data_out, 8'hA5);
    switches = 8'h5A; #1;
    chk("R4 data follows", data_out, 8'h5A);
    // R6: read at another address, read without I/O cycle
    addr = 8'h7F; #1;
    chk("R6 other addr", {7'b0, data_oe}, 8'h00);
    addr = 8'hFF; io_cyc_n = 1'b1; #1;
    chk("R6 no io cycle", {7'b0, data_oe}, 8'h00);
    rd_n = 1'b1; #1;
    chk("R6 idle", {7'b0, data_oe}, 8'h00);

    // R7/R8: request edge
    @(negedge clk); req_in = 1'b1;
    @(negedge clk);
    chk("R7 lamp set", {7'b0, lamp}, 8'h01);
    chk("R8 disabled", {7'b0, irq_n}, 8'h01);
    int_en = 1'b1; #1;
    chk("R8 enabled", {7'b0, irq_n}, 8'h00);

    // R5: acknowledge together with a port read
    @(negedge clk);
    addr = 8'hFF; io_cyc_n = 1'b0; iack_n = 1'b0; rd_n = 1'b0; #1;
    chk("R5 oe", {7'b0, data_oe}, 8'h01);
    chk("R5 vector", data_out, 8'h02);
    @(negedge clk);
    chk("R9 held during ack", {7'b0, lamp}, 8'h01);
    io_cyc_n = 1'b1; iack_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk("R9 cleared", {7'b0, lamp}, 8'h00);
    chk("R8 released", {7'b0, irq_n}, 8'h01);
    // R7: level still high does not set again
    repeat (2) @(negedge clk);
    chk("R7 level no reset", {7'b0, lamp}, 8'h00);

    // R9: ack end and new request edge on the same clock edge
    req_in = 1'b0;
    @(negedge clk); req_in = 1'b1;
    @(negedge clk); req_in = 1'b0;
    io_cyc_n = 1'b0; iack_n = 1'b0;
    @(negedge clk);
    io_cyc_n = 1'b1; iack_n = 1'b1; req_in = 1'b1;
    @(negedge clk);
    chk("R9 collision keeps", {7'b0, lamp}, 8'h01);
    io_cyc_n = 1'b0; iack_n = 1'b0;
    @(negedge clk);
    io_cyc_n = 1'b1; iack_n = 1'b1;
    @(negedge clk);
    chk("R9 second ack clears", {7'b0, lamp}, 8'h00);

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 pending writes actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule